// File: doc/BRIEF.md
# Shift-Rotate Unit with Carry Output

This block is the operand shifter of a processor datapath. It takes a 32-bit operand and an 8-bit shift amount and does one of three things: a logical shift left, a rotate right, or a single-bit rotate right through the carry flag. It also works out the carry flag that the operation leaves behind. A flag-update enable decides whether that carry is written. When the carry is written, the carry-written output goes high. When it is not written, the incoming carry appears unchanged on the carry output.

The shifting logic is combinational. An optional output register, chosen by a parameter and on by default, gives the ALU and flag logic that follow a full cycle. The carry rules are exact at the edges: a zero amount, an amount of exactly 32, amounts above 32, and rotate through carry each have their own rule.

Top module: `srot_unit`

## Requirements
- R1: When the operation select is 00 (shift left) and the amount n is 1 to 31, the result is the operand shifted left by n with zeros filled in at the bottom. When update is enabled, the carry becomes operand bit[32-n] and carry-written is 1.
- R2: When the select is 00 and the amount is 0, the result equals the operand, the carry output equals the carry input, and carry-written is 0, whatever the update enable is.
- R3: When the select is 00 and the amount is 32 or more, the result is all zeros. When update is enabled, the carry becomes operand bit[0] for an amount of exactly 32, and 0 for an amount of 33 or more.
- R4: When the select is 01 (rotate right), only the low 5 bits m of the amount are used. For m from 1 to 31 the result is the operand rotated right by m. When update is enabled, the carry becomes operand bit[m-1].
- R5: When the select is 01 and the amount is non-zero with its low 5 bits all zero (32, 64, … 224), the result equals the operand. When update is enabled, the carry becomes operand bit[31].
- R6: When the select is 01 and the amount is 0, the result equals the operand, the carry is unchanged, and carry-written is 0.
- R7: When the select is 10 (rotate through carry), the result is {carry input, operand[31:1]} and the amount is ignored. When update is enabled, the carry becomes operand bit[0].
- R8: The select value 11 is reserved. It passes the operand through, the carry is unchanged, and carry-written is 0.
- R9: When the update enable is 0, the carry output equals the carry input and carry-written is 0 for every operation. The result is the same as when update is enabled.
- R10: With the output register on (the default), the outputs take on the values for an input set one clock edge after it is applied, and hold them until the next edge. While the synchronous reset is high, the result, the carry and carry-written are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| opnd_i | input | 32 | Operand to shift or rotate |
| amt_i | input | 8 | Shift or rotate amount |
| op_i | input | 2 | Operation: 00 shift left, 01 rotate right, 10 rotate through carry, 11 pass |
| cin_i | input | 1 | Incoming carry flag |
| upd_i | input | 1 | Flag-update enable |
| res_o | output | 32 | Shifted or rotated result |
| cout_o | output | 1 | Next carry flag |
| cwr_o | output | 1 | High when this operation wrote the carry |

## Verification
The shifters are log-depth stage chains, so a wrong stage corrupts only those amounts whose matching amount bit is set. A sweep over all 256 amounts shows such a fault on the very next registered output. A wrong carry tap or a wrong overflow decode shows up at one amount in particular: 0, 32, 33 or a multiple of 32. So each of those amounts is applied with both carry-input values. A fault in the carry-write qualification shows up as carry-written going high for a zero amount or for the reserved select, or as the carry changing while update is off. Each of these is visible one clock after the stimulus.

// File: rtl/srot_pkg.sv
package srot_pkg;

    localparam int DATA_W = 32;
    localparam int AMT_W  = 8;
    localparam int SH_W   = $clog2(DATA_W);

    typedef enum logic [1:0] {
        OP_LSL  = 2'b00,
        OP_ROR  = 2'b01,
        OP_RRC  = 2'b10,
        OP_PASS = 2'b11
    } srot_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cout;
        logic              cwr;
    } srot_out_t;

    localparam int OUT_W = $bits(srot_out_t);

    // carry is written only when enabled and the operation defines a new carry
    function automatic logic carry_written(input logic upd, input logic act);
        return upd & act;
    endfunction

endpackage

// File: rtl/srot_lsl.sv
module srot_lsl #(
    parameter int W  = srot_pkg::DATA_W,
    parameter int AW = srot_pkg::AMT_W
) (
    input  logic [W-1:0]  opnd_i,
    input  logic [AW-1:0] amt_i,
    output logic [W-1:0]  res_o,
    output logic          cbit_o,
    output logic          cact_o
);
    localparam int SW  = $clog2(W);
    localparam int STG = SW + 1;   // covers amounts up to 2W-1

    // one guard bit above the operand catches the last bit shifted out
    logic [W:0] stg [0:STG];
    logic       far;

    assign stg[0] = {1'b0, opnd_i};

    genvar k;
    generate
        for (k = 0; k < STG; k++) begin : g_stage
            assign stg[k+1] = amt_i[k] ? (stg[k] << (1 << k)) : stg[k];
        end
        if (AW > STG) begin : g_far
            assign far = |amt_i[AW-1:STG];
        end else begin : g_near
            assign far = 1'b0;
        end
    endgenerate

    assign res_o  = far ? '0 : stg[STG][W-1:0];
    assign cbit_o = far ? 1'b0 : stg[STG][W];
    assign cact_o = |amt_i;

endmodule

// File: rtl/srot_ror.sv
module srot_ror #(
    parameter int W  = srot_pkg::DATA_W,
    parameter int AW = srot_pkg::AMT_W
) (
    input  logic [W-1:0]  opnd_i,
    input  logic [AW-1:0] amt_i,
    output logic [W-1:0]  res_o,
    output logic          cbit_o,
    output logic          cact_o
);
    localparam int SW = $clog2(W);

    logic [W-1:0] rot [0:SW];

    assign rot[0] = opnd_i;

    genvar k;
    generate
        for (k = 0; k < SW; k++) begin : g_stage
            localparam int S = 1 << k;
            assign rot[k+1] = amt_i[k] ? {rot[k][S-1:0], rot[k][W-1:S]} : rot[k];
        end
    endgenerate

    assign res_o  = rot[SW];
    // the bit that lands on top is always the last one rotated round
    assign cbit_o = rot[SW][W-1];
    assign cact_o = |amt_i;

endmodule

// File: rtl/srot_rrc.sv
module srot_rrc #(
    parameter int W = srot_pkg::DATA_W
) (
    input  logic [W-1:0] opnd_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cbit_o,
    output logic         cact_o
);
    assign res_o  = {cin_i, opnd_i[W-1:1]};
    assign cbit_o = opnd_i[0];
    assign cact_o = 1'b1;
endmodule

// File: rtl/srot_oreg.sv
module srot_oreg #(
    parameter int  DW      = srot_pkg::OUT_W,
    parameter bit  REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] d_i,
    output logic [DW-1:0] q_o
);
    generate
        if (REG_OUT) begin : g_reg
            logic [DW-1:0] q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= '0;
                else     q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_wire
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/srot_unit.sv
module srot_unit
    import srot_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic [1:0]        op_i,
    input  logic              cin_i,
    input  logic              upd_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o,
    output logic              cwr_o
);
    logic [DATA_W-1:0] lsl_res, ror_res, rrc_res;
    logic              lsl_c, ror_c, rrc_c;
    logic              lsl_a, ror_a, rrc_a;

    srot_lsl #(.W(DATA_W), .AW(AMT_W)) u_lsl (
        .opnd_i(opnd_i), .amt_i(amt_i),
        .res_o(lsl_res), .cbit_o(lsl_c), .cact_o(lsl_a)
    );

    srot_ror #(.W(DATA_W), .AW(AMT_W)) u_ror (
        .opnd_i(opnd_i), .amt_i(amt_i),
        .res_o(ror_res), .cbit_o(ror_c), .cact_o(ror_a)
    );

    srot_rrc #(.W(DATA_W)) u_rrc (
        .opnd_i(opnd_i), .cin_i(cin_i),
        .res_o(rrc_res), .cbit_o(rrc_c), .cact_o(rrc_a)
    );

    srot_out_t nxt, cur;
    logic      sel_c, sel_a;

    always_comb begin
        nxt.res = opnd_i;
        sel_c   = cin_i;
        sel_a   = 1'b0;
        unique case (srot_op_e'(op_i))
            OP_LSL:  begin nxt.res = lsl_res; sel_c = lsl_c; sel_a = lsl_a; end
            OP_ROR:  begin nxt.res = ror_res; sel_c = ror_c; sel_a = ror_a; end
            OP_RRC:  begin nxt.res = rrc_res; sel_c = rrc_c; sel_a = rrc_a; end
            OP_PASS: begin nxt.res = opnd_i;  sel_c = cin_i; sel_a = 1'b0;  end
        endcase
        nxt.cwr  = carry_written(upd_i, sel_a);
        nxt.cout = nxt.cwr ? sel_c : cin_i;
    end

    srot_oreg #(.DW(OUT_W), .REG_OUT(REG_OUT)) u_oreg (
        .clk(clk), .rst(rst), .d_i(nxt), .q_o(cur)
    );

    assign res_o  = cur.res;
    assign cout_o = cur.cout;
    assign cwr_o  = cur.cwr;

endmodule

// File: rtl/srot_unit_chk.sv
module srot_unit_chk
    import srot_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] opnd_i,
    input logic [AMT_W-1:0]  amt_i,
    input logic [1:0]        op_i,
    input logic              cin_i,
    input logic              upd_i,
    input logic [DATA_W-1:0] res_o,
    input logic              cout_o,
    input logic              cwr_o
);
    logic [DATA_W-1:0] d_opnd;
    logic [AMT_W-1:0]  d_amt;
    logic [1:0]        d_op;
    logic              d_cin, d_upd;
    logic              armed;

    generate
        if (REG_OUT) begin : g_dly
            always_ff @(posedge clk) begin
                d_opnd <= opnd_i;
                d_amt  <= amt_i;
                d_op   <= op_i;
                d_cin  <= cin_i;
                d_upd  <= upd_i;
            end
        end else begin : g_now
            assign d_opnd = opnd_i;
            assign d_amt  = amt_i;
            assign d_op   = op_i;
            assign d_cin  = cin_i;
            assign d_upd  = upd_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    a_r9_carry_held: assert property (@(posedge clk) disable iff (rst)
        (armed && !d_upd) |-> (cout_o == d_cin && !cwr_o));

    a_r2_lsl_zero: assert property (@(posedge clk) disable iff (rst)
        (armed && d_op == 2'b00 && d_amt == '0) |-> (res_o == d_opnd && cout_o == d_cin && !cwr_o));

    a_r3_lsl_clear: assert property (@(posedge clk) disable iff (rst)
        (armed && d_op == 2'b00 && d_amt >= AMT_W'(DATA_W)) |-> (res_o == '0));

    a_r3_lsl_far_carry: assert property (@(posedge clk) disable iff (rst)
        (armed && d_op == 2'b00 && d_amt > AMT_W'(DATA_W) && d_upd) |-> (!cout_o && cwr_o));

    a_r5_ror_full: assert property (@(posedge clk) disable iff (rst)
        (armed && d_op == 2'b01 && d_amt[SH_W-1:0] == '0 && d_amt != '0)
        |-> (res_o == d_opnd && (!d_upd || cout_o == d_opnd[DATA_W-1])));

    a_r6_ror_zero: assert property (@(posedge clk) disable iff (rst)
        (armed && d_op == 2'b01 && d_amt == '0) |-> (res_o == d_opnd && !cwr_o));

    a_r7_rrc_top: assert property (@(posedge clk) disable iff (rst)
        (armed && d_op == 2'b10) |-> (res_o[DATA_W-1] == d_cin && (!d_upd || cout_o == d_opnd[0])));

    a_r8_pass: assert property (@(posedge clk) disable iff (rst)
        (armed && d_op == 2'b11) |-> (res_o == d_opnd && cout_o == d_cin && !cwr_o));

    a_r9_write_needs_upd: assert property (@(posedge clk) disable iff (rst)
        (armed && cwr_o) |-> d_upd);

endmodule

bind srot_unit srot_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst(rst), .opnd_i(opnd_i), .amt_i(amt_i), .op_i(op_i),
    .cin_i(cin_i), .upd_i(upd_i), .res_o(res_o), .cout_o(cout_o), .cwr_o(cwr_o)
);

// File: tb/srot_unit_tb.sv
module srot_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd = '0;
    logic [7:0]  amt = '0;
    logic [1:0]  op = '0;
    logic        cin = 1'b0;
    logic        upd = 1'b0;
    logic [31:0] res;
    logic        cout, cwr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    srot_unit #(.REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst(rst), .opnd_i(opnd), .amt_i(amt), .op_i(op),
        .cin_i(cin), .upd_i(upd), .res_o(res), .cout_o(cout), .cwr_o(cwr)
    );

    // behavioural model built bit by bit from the requirements
    function automatic logic [33:0] model(input logic [1:0] o, input logic [31:0] a,
                                          input logic [7:0] n, input logic ci, input logic up);
        logic [31:0] r;
        logic        c, act;
        int          nn, e;
        nn  = int'(n);
        r   = a;
        c   = ci;
        act = 1'b0;
        case (o)
            2'b00: begin
                act = (nn != 0);
                for (int i = 0; i < 32; i++) r[i] = (i - nn >= 0) ? a[i - nn] : 1'b0;
                if (nn == 0)       c = ci;
                else if (nn <= 32) c = a[32 - nn];
                else               c = 1'b0;
            end
            2'b01: begin
                act = (nn != 0);
                e = nn % 32;
                if (e == 0) e = 32;
                if (nn != 0) begin
                    for (int i = 0; i < 32; i++) r[i] = a[(i + e) % 32];
                    c = a[e - 1];
                end
            end
            2'b10: begin
                act = 1'b1;
                r = {ci, a[31:1]};
                c = a[0];
            end
            default: begin
                act = 1'b0;
                r = a;
            end
        endcase
        if (!(up && act)) begin
            c   = ci;
            act = 1'b0;
        end
        return {r, c, act};
    endfunction

    task automatic check(input string tag, input logic [33:0] exp);
        checks++;
        if ({res, cout, cwr} !== exp) begin
            errors++;
            $display("FAIL %s op=%b amt=%0d got res=%h c=%b w=%b exp res=%h c=%b w=%b",
                     tag, op, amt, res, cout, cwr, exp[33:2], exp[1], exp[0]);
        end
    endtask

    // drive on a falling edge, sample on the next falling edge
    task automatic apply(input string tag, input logic [1:0] o, input logic [31:0] a,
                         input logic [7:0] n, input logic ci, input logic up);
        @(negedge clk);
        op = o; opnd = a; amt = n; cin = ci; upd = up;
        @(negedge clk);
        check(tag, model(o, a, n, ci, up));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        opnd = 32'hFFFF_FFFF; amt = 8'd3; op = 2'b10; cin = 1'b1; upd = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 reset", 34'd0);
        rst = 1'b0;
    endtask

    task automatic t_lsl_sweep;
        for (int n = 0; n < 256; n++) begin
            for (int c = 0; c < 2; c++) begin
                logic [31:0] v;
                v = (n % 3 == 0) ? 32'h8000_0001 : $urandom;
                if (n == 0)       apply("R2 lsl zero", 2'b00, v, n[7:0], c[0], 1'b1);
                else if (n < 32)  apply("R1 lsl", 2'b00, v, n[7:0], c[0], 1'b1);
                else              apply("R3 lsl big", 2'b00, v, n[7:0], c[0], 1'b1);
            end
        end
        apply("R3 lsl 32 bit0", 2'b00, 32'h0000_0001, 8'd32, 1'b0, 1'b1);
        apply("R3 lsl 33", 2'b00, 32'hFFFF_FFFF, 8'd33, 1'b1, 1'b1);
    endtask

    task automatic t_ror_sweep;
        for (int n = 0; n < 256; n++) begin
            for (int c = 0; c < 2; c++) begin
                logic [31:0] v;
                v = (n % 5 == 0) ? 32'h8000_0000 : $urandom;
                if (n == 0)           apply("R6 ror zero", 2'b01, v, n[7:0], c[0], 1'b1);
                else if (n % 32 == 0) apply("R5 ror full", 2'b01, v, n[7:0], c[0], 1'b1);
                else                  apply("R4 ror", 2'b01, v, n[7:0], c[0], 1'b1);
            end
        end
    endtask

    task automatic t_rrc;
        apply("R7 rrc", 2'b10, 32'h0000_0001, 8'd0, 1'b0, 1'b1);
        apply("R7 rrc", 2'b10, 32'hFFFF_FFFE, 8'd200, 1'b1, 1'b1);
        for (int i = 0; i < 16; i++)
            apply("R7 rrc", 2'b10, $urandom, 8'($urandom), i[0], 1'b1);
    endtask

    task automatic t_pass;
        for (int i = 0; i < 8; i++)
            apply("R8 pass", 2'b11, $urandom, 8'($urandom), i[0], 1'b1);
    endtask

    task automatic t_noupd;
        for (int o = 0; o < 4; o++) begin
            apply("R9 no update", o[1:0], 32'hC000_0003, 8'd1, 1'b0, 1'b0);
            apply("R9 no update", o[1:0], 32'h3FFF_FFFC, 8'd32, 1'b1, 1'b0);
            apply("R9 no update", o[1:0], $urandom, 8'd40, 1'b0, 1'b0);
        end
    endtask

    task automatic t_latency;
        logic [33:0] first;
        apply("R10 first", 2'b00, 32'h0000_00F0, 8'd4, 1'b0, 1'b1);
        first = model(2'b00, 32'h0000_00F0, 8'd4, 1'b0, 1'b1);
        @(negedge clk);
        op = 2'b01; opnd = 32'h1234_5678; amt = 8'd8; cin = 1'b1; upd = 1'b1;
        #1;
        check("R10 hold before edge", first);
        @(negedge clk);
        check("R10 after edge", model(2'b01, 32'h1234_5678, 8'd8, 1'b1, 1'b1));
    endtask

    initial begin
        t_reset();
        t_latency();
        t_lsl_sweep();
        t_ror_sweep();
        t_rrc();
        t_pass();
        t_noupd();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule